// File: doc/BRIEF.md
# Grid-Tied Converter Supervisory Mode Controller

This block is the operating-mode sequencer of a grid-tied power converter. After reset it waits through a short initialisation interval. It then sits in standby until it is allowed to deliver power. While running it raises one enable that gates both the switching PWM and the thyristor bridge control. It drops to a fault mode whenever the protection logic reports a problem. A 1 ms tick input is the timebase for every interval.

The operator has one debounced key. A long hold of that key has a different meaning in each mode: it starts the converter from standby, stops it while running, and clears a fault. A status LED shows the mode with a slow flash, a slower flash, or a steady light. A start never takes effect immediately. The block first arms itself and then waits for the next grid zero-crossing strobe. At that strobe it enables the power stage and pulses a request for the current loop to begin from zero demand. When auto-start is enabled, the controller also starts and stops on its own as the conditions-OK input changes.

Top module: `inv_mode_ctrl`

## Requirements
- R1: While reset is asserted, `mode_o` reads 0 (power-on), the enable is low and the LED is off. After INIT_TICKS ticks the mode becomes 1 (standby). The mode codes are 0 power-on, 1 standby, 2 running and 3 fault.
- R2: `pwr_en_o` is high exactly when the mode is running (code 2). It is low in power-on, standby and fault.
- R3: In standby, a long press arms a start (`start_wait_o` high) only if `cond_ok_i` is high. An armed start moves to running only on a cycle where `zc_i` is high. If `cond_ok_i` goes low while armed, the arming is cancelled.
- R4: In running, a long press returns the block to standby.
- R5: In fault, a long press returns the block to standby, unless `fault_i` is still high.
- R6: A long press fires when the key has been held for more than HOLD_TICKS ticks, that is on tick HOLD_TICKS+1. A hold of exactly HOLD_TICKS ticks does nothing. A press fires at most once, however long the key stays held.
- R7: The LED is lit for the first FLASH_MS ticks of each STBY_MS-tick period in standby, and of each RUN_MS-tick period in running. It is lit steadily in fault and off in power-on. The blink count restarts on every mode change.
- R8: `fault_i` high on a clock edge forces the fault mode at that edge, from any mode, and clears any armed start.
- R9: With `auto_en_i` high, a standby block whose `cond_ok_i` is high arms a start without a key press. A running block whose `cond_ok_i` goes low returns to standby.
- R10: The enable rises only at an edge where `zc_i` was sampled high. `zref_o` is high for exactly the first cycle of running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle 1 ms strobe |
| key_i | input | 1 | Debounced user key, high when pressed |
| cond_ok_i | input | 1 | Grid and input conditions suitable for export |
| fault_i | input | 1 | Protection fault request |
| auto_en_i | input | 1 | Enable automatic start and stop |
| zc_i | input | 1 | Grid zero-crossing strobe |
| pwr_en_o | output | 1 | Enable for the PWM and thyristor drives |
| led_o | output | 1 | Status LED |
| mode_o | output | 2 | Current mode code |
| start_wait_o | output | 1 | Start armed, waiting for a zero crossing |
| zref_o | output | 1 | Pulse: start the current reference from zero |

## Verification
On every cycle, the assertions check four things. The fault input always wins. The enable never rises without a zero-crossing strobe. A held key never produces two long-press events in a row. The LED stays lit whenever the previous mode was fault. Only the bench scenarios can show the rest: the hold-time boundary at exactly 1000 versus 1001 ticks, the flash phase at chosen points across 1.2 s and 2.4 s periods, cancelling an armed start, and the different effect of the same long press in each mode.

// File: rtl/inv_mode_pkg.sv
package inv_mode_pkg;
  typedef enum logic [1:0] {
    M_POR   = 2'd0,
    M_STBY  = 2'd1,
    M_RUN   = 2'd2,
    M_FAULT = 2'd3
  } mode_e;
endpackage

// File: rtl/key_hold.sv
module key_hold #(
  parameter int HOLD_TICKS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic key_i,
  output logic long_o
);
  localparam int CW = $clog2(HOLD_TICKS + 2);
  localparam logic [CW-1:0] HOLD_C = CW'(HOLD_TICKS);
  localparam logic [CW-1:0] CAP_C  = CW'(HOLD_TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic          long_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      long_q <= 1'b0;
    end else begin
      long_q <= key_i && tick_i && (cnt_q == HOLD_C);
      if (!key_i)                        cnt_q <= '0;
      else if (tick_i && cnt_q != CAP_C) cnt_q <= cnt_q + 1'b1; // saturate: one event per press
    end
  end

  assign long_o = long_q;

  assert_long_once_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_q |=> !long_q);
endmodule

// File: rtl/led_blink.sv
module led_blink
  import inv_mode_pkg::*;
#(
  parameter int STBY_MS  = 1200,
  parameter int RUN_MS   = 2400,
  parameter int FLASH_MS = 100
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  mode_e mode_i,
  output logic  led_o
);
  localparam int MAXP = (RUN_MS > STBY_MS) ? RUN_MS : STBY_MS;
  localparam int CW   = $clog2(MAXP + 1);
  localparam logic [CW-1:0] STBY_LAST = CW'(STBY_MS - 1);
  localparam logic [CW-1:0] RUN_LAST  = CW'(RUN_MS - 1);
  localparam logic [CW-1:0] FLASH_C   = CW'(FLASH_MS);

  logic [CW-1:0] cnt_q, cnt_nx, last;
  mode_e         prev_q;
  logic          led_q, led_nx;

  always_comb begin
    last = (mode_i == M_RUN) ? RUN_LAST : STBY_LAST;
    if (mode_i != prev_q)  cnt_nx = '0;
    else if (tick_i)       cnt_nx = (cnt_q >= last) ? '0 : cnt_q + 1'b1;
    else                   cnt_nx = cnt_q;
    unique case (mode_i)
      M_STBY, M_RUN: led_nx = (cnt_nx < FLASH_C);
      M_FAULT:       led_nx = 1'b1;
      default:       led_nx = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      prev_q <= M_POR;
      led_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      prev_q <= mode_i;
      led_q  <= led_nx;
    end
  end

  assign led_o = led_q;

  assert_fault_led_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(mode_i) == M_FAULT) |-> led_o);
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
  import inv_mode_pkg::*;
#(
  parameter int INIT_TICKS = 16
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  long_i,
  input  logic  cond_ok_i,
  input  logic  fault_i,
  input  logic  auto_en_i,
  input  logic  zc_i,
  output mode_e mode_o,
  output logic  arm_o,
  output logic  en_o,
  output logic  zref_o
);
  localparam int IW = $clog2(INIT_TICKS + 1);
  localparam logic [IW-1:0] INIT_LAST = IW'(INIT_TICKS - 1);

  mode_e         mode_q, mode_nx;
  logic          arm_q, arm_nx, zref_q, zref_nx;
  logic [IW-1:0] init_q, init_nx;

  always_comb begin
    mode_nx = mode_q;
    arm_nx  = arm_q;
    zref_nx = 1'b0;
    init_nx = init_q;
    unique case (mode_q)
      M_POR: if (tick_i) begin
        if (init_q == INIT_LAST) mode_nx = M_STBY;
        else                     init_nx = init_q + 1'b1;
      end
      M_STBY: begin
        if (arm_q) begin
          if (!cond_ok_i) arm_nx = 1'b0;
          else if (zc_i) begin
            mode_nx = M_RUN;
            arm_nx  = 1'b0;
            zref_nx = 1'b1;
          end
        end else if (cond_ok_i && (long_i || auto_en_i)) begin
          arm_nx = 1'b1;
        end
      end
      M_RUN:   if (long_i || (auto_en_i && !cond_ok_i)) mode_nx = M_STBY;
      default: if (long_i) mode_nx = M_STBY;
    endcase
    if (fault_i) begin
      mode_nx = M_FAULT;
      arm_nx  = 1'b0;
      zref_nx = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_POR;
      arm_q  <= 1'b0;
      zref_q <= 1'b0;
      init_q <= '0;
    end else begin
      mode_q <= mode_nx;
      arm_q  <= arm_nx;
      zref_q <= zref_nx;
      init_q <= init_nx;
    end
  end

  assign mode_o = mode_q;
  assign arm_o  = arm_q;
  assign en_o   = (mode_q == M_RUN);
  assign zref_o = zref_q;

  assert_fault_entry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(fault_i)) |-> (mode_q == M_FAULT && !arm_q));
  assert_en_at_zc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_o) |-> ($past(zc_i) && $past(arm_q)));
  assert_zref_run_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zref_q |-> (en_o && $past(!en_o)));
endmodule

// File: rtl/inv_mode_ctrl.sv
module inv_mode_ctrl
  import inv_mode_pkg::*;
#(
  parameter int INIT_TICKS = 16,
  parameter int HOLD_TICKS = 1000,
  parameter int STBY_MS    = 1200,
  parameter int RUN_MS     = 2400,
  parameter int FLASH_MS   = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       key_i,
  input  logic       cond_ok_i,
  input  logic       fault_i,
  input  logic       auto_en_i,
  input  logic       zc_i,
  output logic       pwr_en_o,
  output logic       led_o,
  output logic [1:0] mode_o,
  output logic       start_wait_o,
  output logic       zref_o
);
  logic  long_ev;
  mode_e mode;

  key_hold #(.HOLD_TICKS(HOLD_TICKS)) u_key (
    .clk_i, .rst_ni, .tick_i, .key_i, .long_o(long_ev)
  );

  mode_fsm #(.INIT_TICKS(INIT_TICKS)) u_fsm (
    .clk_i, .rst_ni, .tick_i, .long_i(long_ev), .cond_ok_i, .fault_i,
    .auto_en_i, .zc_i, .mode_o(mode), .arm_o(start_wait_o),
    .en_o(pwr_en_o), .zref_o
  );

  led_blink #(.STBY_MS(STBY_MS), .RUN_MS(RUN_MS), .FLASH_MS(FLASH_MS)) u_led (
    .clk_i, .rst_ni, .tick_i, .mode_i(mode), .led_o
  );

  assign mode_o = mode;
endmodule

// File: tb/sim_inv_mode_ctrl.sv
module sim_inv_mode_ctrl;
  logic clk = 1'b0, rst_ni = 1'b0, tick = 1'b0, key = 1'b0;
  logic cond = 1'b0, fault = 1'b0, auto_en = 1'b0, zc = 1'b0;
  logic pwr_en, led, start_wait, zref;
  logic [1:0] mode;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { string req; int sel; int exp; } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  inv_mode_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .key_i(key),
    .cond_ok_i(cond), .fault_i(fault), .auto_en_i(auto_en), .zc_i(zc),
    .pwr_en_o(pwr_en), .led_o(led), .mode_o(mode),
    .start_wait_o(start_wait), .zref_o(zref)
  );

  // monitor: 0 mode, 1 enable, 2 led, 3 zref, 4 start_wait
  always @(negedge clk) begin : mon
    item_t it;
    int act;
    while (q.size() > 0) begin
      it = q.pop_front();
      case (it.sel)
        0: act = int'(mode);
        1: act = int'(pwr_en);
        2: act = int'(led);
        3: act = int'(zref);
        default: act = int'(start_wait);
      endcase
      checks++;
      if (act != it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic chk(input string req, input int sel, input int exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic flush();
    @(negedge clk); #1;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 tick = 1'b1;
      @(posedge clk); #1 tick = 1'b0;
    end
  endtask

  task automatic press(input int n);
    key = 1'b1;
    wait_ticks(n);
    key = 1'b0;
    step(1);
  endtask

  task automatic zc_pulse();
    @(posedge clk); #1 zc = 1'b1;
    @(posedge clk); #1 zc = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    chk("R1 reset mode", 0, 0); chk("R1 reset en", 1, 0); chk("R1 reset led", 2, 0); flush();
    @(posedge clk); #1 rst_ni = 1'b1;
    wait_ticks(5);
    chk("R1 still power-on", 0, 0); chk("R7 por led off", 2, 0); flush();
    wait_ticks(15);
    chk("R1 standby", 0, 1); chk("R2 standby en", 1, 0); flush();
    wait_ticks(50);  chk("R7 stby flash on", 2, 1); flush();
    wait_ticks(100); chk("R7 stby off", 2, 0); flush();
    wait_ticks(1000); chk("R7 stby off late", 2, 0); flush();
    wait_ticks(100); chk("R7 stby second flash", 2, 1); flush();

    press(1100);
    chk("R3 no start without cond", 0, 1); chk("R3 not armed", 4, 0); flush();
    cond = 1'b1;
    press(1000);
    chk("R6 exact hold no action", 4, 0); flush();
    press(1001);
    chk("R3 armed", 4, 1); chk("R3 still standby", 0, 1); chk("R10 en waits", 1, 0); flush();
    wait_ticks(5);
    chk("R10 no en before zc", 1, 0); flush();
    zc_pulse();
    chk("R10 zref pulse", 3, 1); chk("R3 running", 0, 2); chk("R2 run en", 1, 1); flush();
    step(1);
    chk("R10 zref one cycle", 3, 0); flush();

    press(3500);
    chk("R4 stop to standby", 0, 1); chk("R6 no re-arm on long hold", 4, 0); flush();
    zc_pulse();
    chk("R6 single action per press", 0, 1); chk("R2 en off", 1, 0); flush();

    auto_en = 1'b1;
    step(2);
    chk("R9 auto arm", 4, 1); flush();
    zc_pulse();
    chk("R9 auto start", 0, 2); flush();
    cond = 1'b0;
    step(2);
    chk("R9 auto stop", 0, 1); chk("R9 en off", 1, 0); flush();
    auto_en = 1'b0;

    cond = 1'b1;
    press(1001);
    chk("R3 armed again", 4, 1); flush();
    cond = 1'b0; step(2);
    chk("R3 arm cancelled", 4, 0); flush();
    cond = 1'b1;
    zc_pulse();
    chk("R3 no start after cancel", 0, 1); flush();

    press(1001);
    zc_pulse();
    chk("R3 run for led", 0, 2); flush();
    wait_ticks(50);   chk("R7 run flash on", 2, 1); flush();
    wait_ticks(1200); chk("R7 run off at 1250", 2, 0); flush();
    wait_ticks(1200); chk("R7 run second flash", 2, 1); flush();

    @(posedge clk); #1 fault = 1'b1;
    @(posedge clk); #1 fault = 1'b0;
    chk("R8 fault from run", 0, 3); chk("R2 fault en off", 1, 0); flush();
    step(2);
    chk("R7 fault led", 2, 1); flush();
    wait_ticks(1300);
    chk("R7 fault led steady", 2, 1); chk("R8 stays fault", 0, 3); flush();
    fault = 1'b1;
    press(1001);
    chk("R5 no clear while fault held", 0, 3); flush();
    fault = 1'b0; step(1);
    press(1001);
    chk("R5 clear to standby", 0, 1); flush();

    rst_ni = 1'b0; step(2); rst_ni = 1'b1; step(1);
    chk("R1 reset again", 0, 0); flush();
    @(posedge clk); #1 fault = 1'b1;
    @(posedge clk); #1 fault = 1'b0;
    chk("R8 fault from power-on", 0, 3); flush();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule